// File: doc/BRIEF.md
# Coprocessor Bus-Cycle Ready Generator

This block sits beside a synchronous host processor bus and recognises the transfer cycles that the host issues to a numeric coprocessor. When the host strobes an I/O cycle to one of two fixed port addresses, the block accepts it and counts the cycle's clocks. It then pulls an active-low ready line for exactly one clock. The delay depends on the direction. A write ends with no wait state. A read always gets one wait state before it ends.

While a coprocessor cycle is in progress, the block drives the 16-bit bus-size request inactive, because every coprocessor transfer is a full 32 bits. A status-enable input acts as a chip select for the block's pad drivers. When it is low, the output enable drops, the bus-size hold is released, and the block's own ready no longer reaches the host. The block also provides the host's combined ready: its own ready is ANDed with the active-low ready of the other bus devices, so any device can end a cycle.

Top module: `cop_ready_gen`

## Requirements
- R1: A cycle is accepted on a clock edge where `adsN` is low, `ioCycle` is 1 and `busAddr` equals 0x800000F8 or 0x800000FC. `copCycle` is high from that edge until the cycle has been terminated.
- R2: A write (`writeCycle` = 1) has no wait state. `readyOutN` is low during the clock that directly follows the acceptance edge, so the host sees ready at the second edge of the cycle.
- R3: A read (`writeCycle` = 0) has exactly one wait state. `readyOutN` stays high for the clock after acceptance and is low for the clock after that.
- R4: `readyOutN` is low for exactly one clock per accepted cycle. The edge that ends that clock also ends the cycle, so `copCycle` returns low.
- R5: A strobe is ignored when the address differs from both ports (for example 0x800000F4, 0x80000100 or 0x000000F8) or when it is a memory cycle (`ioCycle` = 0). An ignored strobe leaves `readyOutN` high and `copCycle` low.
- R6: A strobe that arrives while a cycle is in progress is not accepted. It neither restarts nor extends the current cycle.
- R7: `bs16Hold` is 1 (the block drives the bus-size-16 request inactive) during every clock of an accepted cycle while `statusEn` is 1. It is 0 when no cycle is in progress.
- R8: While `statusEn` is 0, `padEn` is 0, `bs16Hold` is 0, and the block's ready has no effect on `hostReadyN`.
- R9: `hostReadyN` is low when `otherReadyN` is low, or when `readyOutN` is low and `statusEn` is 1. Otherwise it is high.
- R10: The reset `rst` is synchronous and active high. It returns the block to idle (`copCycle` 0, `readyOutN` 1), and a strobe during reset is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| statusEn | input | 1 | Chip select for the output drivers, 1 = drive |
| adsN | input | 1 | Address strobe, active low |
| ioCycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| writeCycle | input | 1 | 1 = write to coprocessor, 0 = read |
| busAddr | input | 32 | Cycle address |
| otherReadyN | input | 1 | Active-low ready from the other bus devices |
| padEn | output | 1 | Output enable of the block's pins |
| readyOutN | output | 1 | Block's own ready, active low, meaningful while padEn is 1 |
| copCycle | output | 1 | Coprocessor cycle in progress |
| bs16Hold | output | 1 | 1 = drive the bus-size-16 request inactive |
| hostReadyN | output | 1 | Combined active-low ready for the host |

## Verification
Inputs change on the falling edge, and acceptance happens on the next rising edge. All results are registered at that acceptance edge, so `copCycle` and `bs16Hold` are due half a clock later. For a write, `readyOutN` is also due then. For a read, it is due one clock later, and the cycle ends one clock after ready. The bench samples at each of the four falling edges that follow acceptance and compares against a per-scenario expected pattern. A rejected strobe must leave all four samples idle. `hostReadyN` and `padEn` are combinational, so they are checked at the same falling edge, after the input change has settled.

// File: rtl/cop_ready_pkg.sv
package cop_ready_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic cycleStart;  // accept: capture direction, clear the wait counter
    logic waitStep;    // advance the wait counter by one
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2
  } cycState_t;

endpackage

// File: rtl/cop_ready_datapath.sv
module cop_ready_datapath
  import cop_ready_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] PORT_A = 32'h800000F8,
  parameter logic [ADDR_W-1:0] PORT_B = 32'h800000FC,
  parameter int WR_WAITS = 0,
  parameter int RD_WAITS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ioCycle,
  input  logic              writeCycle,
  input  ctlStrobes_t       ctl,
  output logic              hit,
  output logic              zeroWait,
  output logic              lastWait
);

  localparam int NPORT = 2;
  localparam int MAX_WAITS = (WR_WAITS > RD_WAITS) ? WR_WAITS : RD_WAITS;
  localparam int CNT_W = (MAX_WAITS < 2) ? 1 : $clog2(MAX_WAITS + 1);
  localparam logic [ADDR_W-1:0] PORT_TABLE [NPORT] = '{PORT_A, PORT_B};

  logic [NPORT-1:0] portHit;
  logic [CNT_W-1:0] waitCnt;
  logic             dirWrite;
  int               curWaits;

  // Address decode, one comparator per port.
  for (genvar g = 0; g < NPORT; g++) begin : gPortCmp
    assign portHit[g] = (busAddr == PORT_TABLE[g]);
  end

  assign hit      = ioCycle && (|portHit);
  assign zeroWait = ((writeCycle ? WR_WAITS : RD_WAITS) == 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCnt  <= '0;
      dirWrite <= 1'b0;
    end else if (ctl.cycleStart) begin
      waitCnt  <= '0;
      dirWrite <= writeCycle;
    end else if (ctl.waitStep) begin
      waitCnt  <= waitCnt + 1'b1;
    end
  end

  assign curWaits = dirWrite ? WR_WAITS : RD_WAITS;
  assign lastWait = ((32'(waitCnt) + 32'd1) == 32'(curWaits));

endmodule

// File: rtl/cop_ready_control.sv
module cop_ready_control
  import cop_ready_pkg::*;
#(
  parameter int WR_WAITS = 0,
  parameter int RD_WAITS = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adsN,
  input  logic        writeCycle,
  input  logic        hit,
  input  logic        zeroWait,
  input  logic        lastWait,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        readyIntN
);

  cycState_t state, stateNext;
  logic accept;

  assign accept = (state == ST_IDLE) && !adsN && hit;

  always_comb begin
    ctl.cycleStart = accept;
    ctl.waitStep   = (state == ST_WAIT) && !lastWait;
    stateNext      = state;
    unique case (state)
      ST_IDLE: if (accept) stateNext = zeroWait ? ST_TERM : ST_WAIT;
      ST_WAIT: if (lastWait) stateNext = ST_TERM;
      ST_TERM: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign busy      = (state != ST_IDLE);
  assign readyIntN = (state != ST_TERM);

  if (WR_WAITS == 0) begin : gWrChk
    // R2
    wr_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
      accept && writeCycle |=> !readyIntN);
  end

  if (RD_WAITS == 1) begin : gRdChk
    // R3
    rd_one_wait_chk: assert property (@(posedge clk) disable iff (rst)
      accept && !writeCycle |=> readyIntN ##1 !readyIntN);
  end

  // R4
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    !readyIntN |=> readyIntN && !busy);

  // R5
  decode_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(hit));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    busy && readyIntN |=> busy);

endmodule

// File: rtl/cop_ready_gen.sv
module cop_ready_gen
  import cop_ready_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] PORT_A = 32'h800000F8,
  parameter logic [ADDR_W-1:0] PORT_B = 32'h800000FC,
  parameter int WR_CLKS = 2,
  parameter int RD_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              statusEn,
  input  logic              adsN,
  input  logic              ioCycle,
  input  logic              writeCycle,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              otherReadyN,
  output logic              padEn,
  output logic              readyOutN,
  output logic              copCycle,
  output logic              bs16Hold,
  output logic              hostReadyN
);

  // A cycle lasts at least two clocks; the extra ones are wait states.
  localparam int WR_WAITS = (WR_CLKS > 2) ? WR_CLKS - 2 : 0;
  localparam int RD_WAITS = (RD_CLKS > 2) ? RD_CLKS - 2 : 0;

  ctlStrobes_t ctl;
  logic hit, zeroWait, lastWait, busy, readyIntN;

  cop_ready_datapath #(
    .ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B),
    .WR_WAITS(WR_WAITS), .RD_WAITS(RD_WAITS)
  ) u_dp (
    .clk(clk), .rst(rst), .busAddr(busAddr), .ioCycle(ioCycle),
    .writeCycle(writeCycle), .ctl(ctl), .hit(hit),
    .zeroWait(zeroWait), .lastWait(lastWait)
  );

  cop_ready_control #(
    .WR_WAITS(WR_WAITS), .RD_WAITS(RD_WAITS)
  ) u_ctl (
    .clk(clk), .rst(rst), .adsN(adsN), .writeCycle(writeCycle),
    .hit(hit), .zeroWait(zeroWait), .lastWait(lastWait),
    .ctl(ctl), .busy(busy), .readyIntN(readyIntN)
  );

  // Pad enables and the ready merge.
  assign padEn      = statusEn;
  assign readyOutN  = readyIntN;
  assign copCycle   = busy;
  assign bs16Hold   = statusEn && busy;
  assign hostReadyN = otherReadyN && (readyIntN || !statusEn);

  // R8
  float_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !padEn |-> !bs16Hold && (hostReadyN == otherReadyN));

endmodule

// File: tb/cop_ready_gen_bench.sv
`timescale 1ns/1ps
module cop_ready_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic statusEn = 1'b1;
  logic adsN = 1'b1;
  logic ioCycle = 1'b0;
  logic writeCycle = 1'b0;
  logic [31:0] busAddr = '0;
  logic otherReadyN = 1'b1;
  logic padEn, readyOutN, copCycle, bs16Hold, hostReadyN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] PA = 32'h800000F8;
  localparam logic [31:0] PB = 32'h800000FC;

  always #2.5 clk = ~clk;

  cop_ready_gen u_cop_ready_gen (
    .clk(clk), .rst(rst), .statusEn(statusEn), .adsN(adsN),
    .ioCycle(ioCycle), .writeCycle(writeCycle), .busAddr(busAddr),
    .otherReadyN(otherReadyN), .padEn(padEn), .readyOutN(readyOutN),
    .copCycle(copCycle), .bs16Hold(bs16Hold), .hostReadyN(hostReadyN)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Strobe one cycle and compare four samples after acceptance.
  // rdyExp/busyExp bit k = expected value at the k-th falling edge after the strobe edge.
  task automatic run_cycle(input string req, input logic [31:0] addr, input logic io,
                           input logic wr, input logic [3:0] rdyExp,
                           input logic [3:0] busyExp, input bit overlap);
    @(negedge clk);
    adsN = 1'b0; busAddr = addr; ioCycle = io; writeCycle = wr;
    @(negedge clk);
    if (overlap) begin
      busAddr = PA; ioCycle = 1'b1; writeCycle = 1'b1;  // strobe kept low while busy
    end else begin
      adsN = 1'b1;
    end
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) adsN = 1'b1;
      chk(req, $sformatf("readyOutN k=%0d", k), readyOutN, rdyExp[k]);
      chk(req, $sformatf("copCycle k=%0d", k), copCycle, busyExp[k]);
      if (statusEn)
        chk("R7", $sformatf("bs16Hold k=%0d", k), bs16Hold, busyExp[k]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    adsN = 1'b0; busAddr = PA; ioCycle = 1'b1; writeCycle = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "copCycle in reset", copCycle, 1'b0);
    chk("R10", "readyOutN in reset", readyOutN, 1'b1);
    adsN = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "copCycle after reset", copCycle, 1'b0);
  endtask

  task automatic t_write();
    run_cycle("R2", PA, 1'b1, 1'b1, 4'b1110, 4'b0001, 1'b0);
    run_cycle("R1", PB, 1'b1, 1'b1, 4'b1110, 4'b0001, 1'b0);
  endtask

  task automatic t_read();
    run_cycle("R3", PB, 1'b1, 1'b0, 4'b1101, 4'b0011, 1'b0);
    run_cycle("R4", PA, 1'b1, 1'b0, 4'b1101, 4'b0011, 1'b0);
  endtask

  task automatic t_reject();
    run_cycle("R5", 32'h800000F4, 1'b1, 1'b1, 4'b1111, 4'b0000, 1'b0);
    run_cycle("R5", 32'h80000100, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b0);
    run_cycle("R5", 32'h000000F8, 1'b1, 1'b1, 4'b1111, 4'b0000, 1'b0);
    run_cycle("R5", PA, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b0);
  endtask

  task automatic t_overlap();
    run_cycle("R6", PB, 1'b1, 1'b0, 4'b1101, 4'b0011, 1'b1);
    @(negedge clk);
    chk("R6", "no extra ready", readyOutN, 1'b1);
  endtask

  task automatic t_disabled();
    statusEn = 1'b0;
    otherReadyN = 1'b1;
    @(negedge clk);
    adsN = 1'b0; busAddr = PA; ioCycle = 1'b1; writeCycle = 1'b0;
    @(negedge clk);
    adsN = 1'b1;
    chk("R8", "padEn", padEn, 1'b0);
    chk("R8", "bs16Hold", bs16Hold, 1'b0);
    @(negedge clk);
    chk("R8", "hostReadyN while own ready floats", hostReadyN, 1'b1);
    repeat (2) @(negedge clk);
    statusEn = 1'b1;
    #1;
    chk("R8", "padEn restored", padEn, 1'b1);
  endtask

  task automatic t_combine();
    @(negedge clk);
    otherReadyN = 1'b0;
    #1 chk("R9", "other ready low", hostReadyN, 1'b0);
    otherReadyN = 1'b1;
    #1 chk("R9", "all idle", hostReadyN, 1'b1);
    adsN = 1'b0; busAddr = PB; ioCycle = 1'b1; writeCycle = 1'b1;
    @(negedge clk);
    adsN = 1'b1;
    chk("R9", "own write ready", hostReadyN, 1'b0);
    @(negedge clk);
    chk("R9", "after termination", hostReadyN, 1'b1);
  endtask

  initial begin
    t_reset();
    t_write();
    t_read();
    t_reject();
    t_overlap();
    t_disabled();
    t_combine();
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule